// File: doc/BRIEF.md
# Dual-channel reload down-counter timer

This peripheral holds two independent 32-bit timer channels behind a small word-addressed register bus. Each channel divides the input clock with its own prescaler and decrements a counter once per prescaled tick. Moving past zero is an underflow: it sets a sticky flag, toggles an output level bit and, when enabled, raises that channel's interrupt line.

Software picks how the channel continues after an underflow. With the reload bit set, the counter restarts from its first reload register and keeps running, which gives a periodic tick source. With the reload bit clear, the channel stops after one underflow, which gives a one-shot event. A counter started from all ones and left running serves as a free-running time base, because the number of elapsed ticks is the bitwise inverse of the counter value.

Software starts a channel by writing the control word with both the trigger and run bits set. It acknowledges the interrupt by writing zero to the flag bit.

Top module: `dual_dn_timer`

## Requirements
- R1: After reset every register of both channels reads 0, and `irq_o` and `lvl_o` are 0.
- R2: Word address bits [1:0] select the register and the bits above them select the channel, so channel c starts at word address 4*c. The registers are: 0 control, 1 counter, 2 reload value A, 3 reload value B. In the control word, bit 0 is trigger, bit 1 run, bit 2 underflow flag, bit 3 interrupt enable, bit 4 reload mode, bit 5 output level and bits [7:6] the prescale select. All other bits read 0.
- R3: A control write with bit 0 and bit 1 both set arms a start, and the first prescaled tick after that write loads the counter from reload value A. Bit 0 always reads back 0, and a trigger written without run loads nothing.
- R4: A control write restarts the prescaler. With prescale select s, ticks fall on every 2^(s+1)-th rising clock edge after the write edge, so select 0 gives a tick every 2 clocks.
- R5: Each tick that is not a load decrements the counter, and a tick that finds the counter at 0 is an underflow. When the counter starts from all ones, the bitwise inverse of the counter equals the number of decrements so far.
- R6: With reload mode set, an underflow loads reload value A and the channel keeps running, so one period is A+1 ticks.
- R7: With reload mode clear, an underflow clears the run bit and the counter holds at 0.
- R8: An underflow sets the flag. A control write with bit 2 = 0 clears it, and a write with bit 2 = 1 leaves it unchanged.
- R9: `irq_o[c]` is high exactly when channel c has both the interrupt-enable bit and the flag set.
- R10: The output level bit toggles on every underflow and drives `lvl_o[c]`.
- R11: Writing 0 to the control register stops the channel, and the counter then holds its value.
- R12: A counter write takes the written value directly. Reload value B is stored and read back but has no other effect.
- R13: The two channels are independent: activity on one never changes the other's registers or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| bus_addr | input | ADDR_W (3) | Word address: channel in the high bits, register in [1:0] |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data of the addressed register |
| irq_o | output | NUM_CH (2) | Per-channel interrupt request |
| lvl_o | output | NUM_CH (2) | Per-channel output level bit |

## Verification
The main sweep starts a channel for every prescale select, several reload values including 0, and both modes. It checks the counter, interrupt and level after every clock against an arithmetic model. The reload value 0 case shows whether underflow happens on a decrement from 0 or on reaching 0, and the sweep over prescale selects shows whether the tick spacing and the first-tick position are right. Periodic and one-shot runs with the same reload value differ only after the first underflow, so together they isolate the reload-versus-stop decision. Directed patterns cover flag write-one versus write-zero, stop and trigger-without-run, an all-ones elapsed-time run, and activity on one channel while the other stays idle.

// File: rtl/dtmr_pkg.sv
`timescale 1ns/1ps
package dtmr_pkg;
  // Control word bit positions (decoded by software)
  localparam int CB_TRIG  = 0;
  localparam int CB_RUN   = 1;
  localparam int CB_FLAG  = 2;
  localparam int CB_IEN   = 3;
  localparam int CB_RELD  = 4;
  localparam int CB_LVL   = 5;
  localparam int CB_PSEL  = 6;

  typedef enum logic [1:0] {
    RG_CTRL  = 2'd0,
    RG_COUNT = 2'd1,
    RG_RLDA  = 2'd2,
    RG_RLDB  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dtmr_prescale.sv
`timescale 1ns/1ps
module dtmr_prescale #(
  parameter int PSEL_W = 2,
  localparam int PC_W  = 2 ** PSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);
  logic [PC_W-1:0] pc_q, pc_d;
  logic [PC_W-1:0] lim;

  always_comb begin
    lim  = PC_W'((32'd1 << (32'(psel) + 32'd1)) - 32'd1);
    tick = run && !restart && (pc_q == lim);
    pc_d = pc_q;
    if (restart) begin
      pc_d = '0;
    end else if (run) begin
      pc_d = tick ? '0 : pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/dtmr_channel.sv
`timescale 1ns/1ps
module dtmr_channel
  import dtmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_cnt,
  input  logic              wr_rlda,
  input  logic              wr_rldb,
  input  logic [DATA_W-1:0] wdata,
  input  reg_sel_e          rsel,
  output logic [DATA_W-1:0] rword,
  output logic              irq,
  output logic              lvl,
  output logic              flag_o,
  output logic              run_o
);
  logic              run_q, run_d;
  logic              flag_q, flag_d;
  logic              ien_q, ien_d;
  logic              reld_q, reld_d;
  logic              lvl_q, lvl_d;
  logic [PSEL_W-1:0] psel_q, psel_d;
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] rlda_q, rlda_d;
  logic [DATA_W-1:0] rldb_q, rldb_d;
  logic              tick;

  dtmr_prescale #(.PSEL_W(PSEL_W)) u_ps (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .restart (wr_ctrl),
    .psel    (psel_q),
    .tick    (tick)
  );

  // next state
  always_comb begin
    run_d  = run_q;
    flag_d = flag_q;
    ien_d  = ien_q;
    reld_d = reld_q;
    lvl_d  = lvl_q;
    psel_d = psel_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    rlda_d = rlda_q;
    rldb_d = rldb_q;

    if (tick) begin
      if (pend_q) begin
        cnt_d  = rlda_q;
        pend_d = 1'b0;
      end else if (cnt_q == '0) begin
        flag_d = 1'b1;
        lvl_d  = ~lvl_q;
        if (reld_q) cnt_d = rlda_q;
        else        run_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end

    if (wr_ctrl) begin
      run_d  = wdata[CB_RUN];
      ien_d  = wdata[CB_IEN];
      reld_d = wdata[CB_RELD];
      lvl_d  = wdata[CB_LVL];
      psel_d = wdata[CB_PSEL +: PSEL_W];
      flag_d = flag_q & wdata[CB_FLAG];
      pend_d = wdata[CB_TRIG] & wdata[CB_RUN];
    end
    if (wr_cnt)  cnt_d  = wdata;
    if (wr_rlda) rlda_d = wdata;
    if (wr_rldb) rldb_d = wdata;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
      reld_q <= 1'b0;
      lvl_q  <= 1'b0;
      psel_q <= '0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      rlda_q <= '0;
      rldb_q <= '0;
    end else begin
      run_q  <= run_d;
      flag_q <= flag_d;
      ien_q  <= ien_d;
      reld_q <= reld_d;
      lvl_q  <= lvl_d;
      psel_q <= psel_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      rlda_q <= rlda_d;
      rldb_q <= rldb_d;
    end
  end

  // read word
  always_comb begin
    rword = '0;
    unique case (rsel)
      RG_CTRL: begin
        rword[CB_RUN]             = run_q;
        rword[CB_FLAG]            = flag_q;
        rword[CB_IEN]             = ien_q;
        rword[CB_RELD]            = reld_q;
        rword[CB_LVL]             = lvl_q;
        rword[CB_PSEL +: PSEL_W]  = psel_q;
      end
      RG_COUNT: rword = cnt_q;
      RG_RLDA:  rword = rlda_q;
      RG_RLDB:  rword = rldb_q;
      default:  rword = '0;
    endcase
  end

  assign irq    = ien_q & flag_q;
  assign lvl    = lvl_q;
  assign flag_o = flag_q;
  assign run_o  = run_q;
endmodule

// File: rtl/dual_dn_timer.sv
`timescale 1ns/1ps
module dual_dn_timer
  import dtmr_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int DATA_W  = 32,
  parameter int PSEL_W  = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq_o,
  output logic [NUM_CH-1:0] lvl_o
);
  reg_sel_e          rsel;
  logic [CH_W-1:0]   csel;
  logic [DATA_W-1:0] rword [NUM_CH];
  logic [NUM_CH-1:0] flag_vec;
  logic [NUM_CH-1:0] run_vec;

  assign rsel = reg_sel_e'(bus_addr[1:0]);
  assign csel = bus_addr[ADDR_W-1:2];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = bus_wr && (csel == CH_W'(c));

    dtmr_channel #(.DATA_W(DATA_W), .PSEL_W(PSEL_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (hit && rsel == RG_CTRL),
      .wr_cnt  (hit && rsel == RG_COUNT),
      .wr_rlda (hit && rsel == RG_RLDA),
      .wr_rldb (hit && rsel == RG_RLDB),
      .wdata   (bus_wdata),
      .rsel    (rsel),
      .rword   (rword[c]),
      .irq     (irq_o[c]),
      .lvl     (lvl_o[c]),
      .flag_o  (flag_vec[c]),
      .run_o   (run_vec[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (csel == CH_W'(c)) bus_rdata = rword[c];
    end
  end
endmodule

// File: rtl/dtmr_checker.sv
`timescale 1ns/1ps
module dtmr_checker #(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] irq_o,
  input logic [NUM_CH-1:0] lvl_o,
  input logic [NUM_CH-1:0] flag_vec,
  input logic [NUM_CH-1:0] run_vec
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_o == '0 && lvl_o == '0));

  assert_trig_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] == 2'd0) |-> !bus_rdata[0]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic cwr;
    assign cwr = bus_wr && bus_addr[1:0] == 2'd0 &&
                 bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(c);

    assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_vec[c] && !cwr) |=> (run_vec[c] || flag_vec[c]));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_vec[c] && !cwr) |=> flag_vec[c]);

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[c] |-> flag_vec[c]);

    assert_level_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cwr && !flag_vec[c]) |=> ($stable(lvl_o[c]) || flag_vec[c]));
  end
endmodule

bind dual_dn_timer dtmr_checker #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .lvl_o     (lvl_o),
  .flag_vec  (flag_vec),
  .run_vec   (run_vec)
);

// File: tb/dual_dn_timer_bench.sv
`timescale 1ns/1ps
module dual_dn_timer_bench;
  localparam int CK_TRIG = 1, CK_RUN = 2, CK_FLAG = 4, CK_IEN = 8, CK_RELD = 16, CK_LVL = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_o, lvl_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  dual_dn_timer u_dual_dn_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .lvl_o(lvl_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int ch, input int rg, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 3'(ch * 4 + rg);
    bus_wr = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input int rg, output logic [31:0] v);
    bus_addr = 3'(ch * 4 + rg);
    #1;
    v = bus_rdata;
  endtask

  // start a channel and check every clock against the arithmetic model
  task automatic sweep(input int ch, input int ps, input int n, input bit per);
    int d, j, und;
    logic [31:0] v, ecnt;
    d = 1 << (ps + 1);
    wr(ch, 0, 0);
    wr(ch, 2, 32'(n));
    wr(ch, 3, 32'(n + 9));
    wr(ch, 0, 32'(CK_TRIG | CK_RUN | CK_IEN | (per ? CK_RELD : 0) | (ps << 6)));
    for (int m = 1; m <= d * (2 * n + 5); m++) begin
      @(negedge clk);
      j = m / d;
      if (j >= 1) begin
        if (per) begin
          ecnt = 32'(n - ((j - 1) % (n + 1)));
          und  = (j - 1) / (n + 1);
        end else begin
          ecnt = (j <= n + 1) ? 32'(n - (j - 1)) : 32'd0;
          und  = (j >= n + 2) ? 1 : 0;
        end
        rd(ch, 1, v);
        chk(per ? "R6 periodic count (R4 R5)" : "R7 one-shot count (R4 R5)", v, ecnt);
        chk("R9 irq follows flag", 32'(irq_o[ch]), 32'(und > 0));
        chk("R10 level toggles", 32'(lvl_o[ch]), 32'(und % 2));
      end
    end
    rd(ch, 0, v);
    if (per) chk("R6 run stays set", 32'(v[1]), 32'd1);
    else     chk("R7 one-shot ctrl readback (R3 R8)", v, 32'(CK_FLAG | CK_IEN | CK_LVL | (ps << 6)));
  endtask

  initial begin
    logic [31:0] v, c1;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int ch = 0; ch < 2; ch++)
      for (int rg = 0; rg < 4; rg++) begin
        rd(ch, rg, v);
        chk("R1 reset register", v, 32'd0);
      end
    chk("R1 reset outputs", {28'd0, irq_o, lvl_o}, 32'd0);
    rst_n = 1'b1;

    // R12 counter and reload B direct access (R2 map)
    wr(0, 1, 32'hDEAD_BEEF);
    rd(0, 1, v); chk("R12 counter write", v, 32'hDEAD_BEEF);
    wr(0, 3, 32'h1234_5678);
    rd(0, 3, v); chk("R12 reload B readback", v, 32'h1234_5678);
    rd(1, 1, v); chk("R13 other channel counter", v, 32'd0);
    rd(1, 3, v); chk("R13 other channel reload B", v, 32'd0);

    // R3 trigger without run loads nothing
    wr(0, 2, 32'd77);
    wr(0, 1, 32'd5);
    wr(0, 0, 32'(CK_TRIG));
    repeat (6) @(negedge clk);
    rd(0, 1, v); chk("R3 trigger without run", v, 32'd5);
    rd(0, 0, v); chk("R3 trigger reads zero", v, 32'd0);

    // R12 reload B has no effect on load
    wr(0, 2, 32'd2);
    wr(0, 3, 32'd9);
    wr(0, 0, 32'(CK_TRIG | CK_RUN));
    repeat (2) @(negedge clk);
    rd(0, 1, v); chk("R12 load uses reload A", v, 32'd2);

    // R13 channel 0 periodic with reload 0, channel 1 idle
    wr(0, 2, 32'd0);
    wr(0, 0, 32'(CK_TRIG | CK_RUN | CK_RELD | CK_IEN));
    repeat (12) @(negedge clk);
    chk("R13 channel 0 active", 32'(irq_o[0]), 32'd1);
    chk("R13 channel 1 outputs idle", {30'd0, irq_o[1], lvl_o[1]}, 32'd0);
    rd(1, 0, v); chk("R13 channel 1 ctrl idle", v, 32'd0);

    // R11 stop holds the counter
    wr(0, 2, 32'd100);
    wr(0, 0, 32'(CK_TRIG | CK_RUN | CK_RELD));
    repeat (20) @(negedge clk);
    wr(0, 0, 32'd0);
    rd(0, 1, c1); chk("R11 value at stop", c1, 32'd91);
    repeat (20) @(negedge clk);
    rd(0, 1, v); chk("R11 counter holds", v, 32'd91);

    // R5 elapsed ticks from all ones
    wr(1, 2, 32'hFFFF_FFFF);
    wr(1, 0, 32'(CK_TRIG | CK_RUN));
    repeat (40) @(negedge clk);
    rd(1, 1, v); chk("R5 inverse equals elapsed", ~v, 32'd19);
    wr(1, 0, 32'd0);

    // R8 flag write-one keeps, write-zero clears
    wr(0, 2, 32'd1);
    wr(0, 0, 32'(CK_TRIG | CK_RUN | CK_IEN));
    repeat (10) @(negedge clk);
    chk("R8 flag set by underflow", 32'(irq_o[0]), 32'd1);
    wr(0, 0, 32'(CK_FLAG | CK_IEN));
    chk("R8 write one keeps flag", 32'(irq_o[0]), 32'd1);
    rd(0, 0, v); chk("R8 ctrl after write one", v, 32'(CK_FLAG | CK_IEN));
    wr(0, 0, 32'(CK_IEN));
    chk("R8 write zero clears flag", 32'(irq_o[0]), 32'd0);
    rd(0, 0, v); chk("R8 ctrl after write zero", v, 32'(CK_IEN));

    // main sweep
    for (int ch = 0; ch < 2; ch++)
      for (int ps = 0; ps < 4; ps++)
        for (int ni = 0; ni < 3; ni++)
          for (int p = 0; p < 2; p++)
            sweep(ch, ps, (ni == 2) ? 3 : ni, p[0]);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule